// File: doc/BRIEF.md
# Concealable Key Row Access Sequencer

This block sequences every cell command that a resistive key array needs, over a 64 by 128 grid of cells. Each row holds one 128-bit device key. Between uses the key stays hidden: every cell in the row is programmed to high conductance, so a plain read returns mostly ones.

An identification request carries a challenge, which is the key number. Number 1 maps to row 0. The block first sweeps the row with recovery pulses, then reads each column, then sweeps the row again with hiding pulses. Only after that does it present the collected 128-bit key. A separate one-time enrollment request forms every cell in the array and then resets every cell.

The array sits behind a simple command port. The block holds one command steady until the array acknowledges it. For reads, the array returns the comparison of the cell current against the reference current.

Top module: `kseq_ctrl`

## Requirements
- R1: During and directly after reset, `busy`, `req_err`, `cell_cmd_valid` and `resp_valid` are all low.
- R2: An identification request with challenge c in 1..64 addresses row c-1 only. Each of its sweeps visits columns 0 to 127 in ascending order.
- R3: A non-enrollment request with challenge 0 or above 64 raises `req_err` for exactly one cycle, in the cycle after the request. It leaves `busy` low and issues no cell command.
- R4: An identification issues 128 recovery commands, then 128 read commands, then 128 hiding commands. When it finishes, every cell of the row is hidden again.
- R5: Bit i of `resp_key` equals the `cell_bit` returned by the read of column i, where 1 means the cell current exceeded the reference. The key is presented with `resp_valid` high for a single cycle.
- R6: A command is accepted only on a clock edge where both `cell_cmd_valid` and `cell_done` are high. Until then, `cell_cmd`, `cell_row` and `cell_col` hold steady.
- R7: `busy` rises in the cycle after an accepted request. It is high during the `resp_valid` cycle and low in the cycle after it.
- R8: Enrollment issues a forming command to all 8192 cells in row-major order, then a reset command to all 8192 cells in the same order. It produces no `resp_valid`.
- R9: A request raised while `busy` is high is ignored. It adds no commands and no response.
- R10: `cell_cmd` encodes forming as 0, hiding (set) as 1, recovery (reset) as 2 and read as 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_enroll | input | 1 | 1 = enrollment, 0 = identification |
| req_chal | input | 7 | Challenge (key number, 1..64 valid) |
| busy | output | 1 | Sequence in progress |
| req_err | output | 1 | One-cycle rejection pulse |
| cell_cmd_valid | output | 1 | Cell command presented |
| cell_cmd | output | 2 | Cell operation code |
| cell_row | output | 6 | Cell row address |
| cell_col | output | 7 | Cell column address |
| cell_done | input | 1 | Array acknowledges the current command |
| cell_bit | input | 1 | Read comparison result, valid with `cell_done` |
| resp_valid | output | 1 | Key strobe |
| resp_key | output | 128 | Recovered key |

## Verification
The array model keeps a hidden flag for each cell, and a read of a hidden cell returns 1. A sequencer that read before recovering, or that hid the row before reading it, therefore returns a key of mostly ones, and the scoreboard rejects it.

The edge challenges 1 and 64 catch an off-by-one in the row decode. The values 0, 65 and 127 catch a range check that is wrong at either end, which would show up as commands issued on a rejected request.

The acknowledge latency varies from command to command. A design that advanced its column without waiting for `cell_done`, or that moved its address while waiting, breaks the command stream. The bench also raises an enrollment request in the middle of an identification. A design that accepted it would start forming commands and overwrite the array.

// File: rtl/kseq_pkg.sv
package kseq_pkg;
    localparam int ARR_ROWS = 64;
    localparam int ARR_COLS = 128;
    localparam int ROW_W    = $clog2(ARR_ROWS);
    localparam int COL_W    = $clog2(ARR_COLS);
    localparam int CHAL_W   = $clog2(ARR_ROWS + 1);

    typedef enum logic [1:0] {
        CMD_FORM  = 2'd0,
        CMD_SET   = 2'd1,
        CMD_RESET = 2'd2,
        CMD_READ  = 2'd3
    } cell_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EFORM,
        ST_ERST,
        ST_IRST,
        ST_IREAD,
        ST_ISET,
        ST_DONE
    } seq_st_e;

    function automatic cell_op_e st_to_op(seq_st_e s);
        case (s)
            ST_EFORM: return CMD_FORM;
            ST_ERST:  return CMD_RESET;
            ST_IRST:  return CMD_RESET;
            ST_IREAD: return CMD_READ;
            ST_ISET:  return CMD_SET;
            default:  return CMD_READ;
        endcase
    endfunction

    function automatic logic st_issues(seq_st_e s);
        return (s == ST_EFORM) || (s == ST_ERST) || (s == ST_IRST) ||
               (s == ST_IREAD) || (s == ST_ISET);
    endfunction
endpackage

// File: rtl/kseq_chal_dec.sv
module kseq_chal_dec #(
    parameter int ROWS   = 64,
    parameter int CHAL_W = 7,
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic [CHAL_W-1:0] chal,
    output logic              ok,
    output logic [ROW_W-1:0]  row
);
    always_comb begin
        ok  = (chal != '0) && (chal <= CHAL_W'(ROWS));
        row = ROW_W'(chal - CHAL_W'(1));
    end
endmodule

// File: rtl/kseq_sweep.sv
module kseq_sweep #(
    parameter int ROWS   = 64,
    parameter int COLS   = 128,
    localparam int ROW_W = $clog2(ROWS),
    localparam int COL_W = $clog2(COLS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [ROW_W-1:0] load_row,
    input  logic             whole,
    input  logic             step,
    output logic [ROW_W-1:0] row,
    output logic [COL_W-1:0] col,
    output logic             last
);
    localparam logic [COL_W-1:0] COL_MAX = COL_W'(COLS - 1);
    localparam logic [ROW_W-1:0] ROW_MAX = ROW_W'(ROWS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            row <= '0;
            col <= '0;
        end else if (load) begin
            row <= load_row;
            col <= '0;
        end else if (step) begin
            if (col == COL_MAX) begin
                col <= '0;
                if (whole) row <= row + ROW_W'(1);
            end else begin
                col <= col + COL_W'(1);
            end
        end
    end

    assign last = (col == COL_MAX) && (!whole || row == ROW_MAX);

    // R2
    row_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !whole) |=> $stable(row));
endmodule

// File: rtl/kseq_capture.sv
module kseq_capture #(
    parameter int COLS   = 128,
    localparam int COL_W = $clog2(COLS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [COL_W-1:0] idx,
    input  logic             bit_in,
    output logic [COLS-1:0]  data
);
    always_ff @(posedge clk) begin
        if (rst) data <= '0;
        else if (we) data[idx] <= bit_in;
    end
endmodule

// File: rtl/kseq_ctrl.sv
module kseq_ctrl
    import kseq_pkg::*;
#(
    parameter int ROWS    = ARR_ROWS,
    parameter int COLS    = ARR_COLS,
    parameter int CHAL_BW = CHAL_W,
    localparam int RW     = $clog2(ROWS),
    localparam int CW     = $clog2(COLS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_enroll,
    input  logic [CHAL_BW-1:0] req_chal,
    output logic               busy,
    output logic               req_err,
    output logic               cell_cmd_valid,
    output logic [1:0]         cell_cmd,
    output logic [RW-1:0]      cell_row,
    output logic [CW-1:0]      cell_col,
    input  logic               cell_done,
    input  logic               cell_bit,
    output logic               resp_valid,
    output logic [COLS-1:0]    resp_key
);
    seq_st_e       st, st_nx;
    logic [RW-1:0] tgt_row, dec_row, load_row;
    logic          chal_ok, start, accept, last, sw_load, sw_step, in_enroll;

    kseq_chal_dec #(.ROWS(ROWS), .CHAL_W(CHAL_BW)) dec_i (
        .chal(req_chal), .ok(chal_ok), .row(dec_row));

    assign start     = req_valid && (st == ST_IDLE);
    assign accept    = cell_cmd_valid && cell_done;
    assign in_enroll = (st == ST_EFORM) || (st == ST_ERST);

    always_comb begin
        st_nx   = st;
        sw_load = 1'b0;
        case (st)
            ST_IDLE: if (start) begin
                if (req_enroll) begin
                    st_nx = ST_EFORM; sw_load = 1'b1;
                end else if (chal_ok) begin
                    st_nx = ST_IRST; sw_load = 1'b1;
                end
            end
            ST_EFORM: if (accept && last) begin st_nx = ST_ERST;  sw_load = 1'b1; end
            ST_ERST:  if (accept && last) st_nx = ST_IDLE;
            ST_IRST:  if (accept && last) begin st_nx = ST_IREAD; sw_load = 1'b1; end
            ST_IREAD: if (accept && last) begin st_nx = ST_ISET;  sw_load = 1'b1; end
            ST_ISET:  if (accept && last) st_nx = ST_DONE;
            default:  st_nx = ST_IDLE;
        endcase
        if (st == ST_IDLE) load_row = req_enroll ? '0 : dec_row;
        else               load_row = in_enroll ? '0 : tgt_row;
    end

    assign sw_step = accept && !last;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            tgt_row <= '0;
            req_err <= 1'b0;
        end else begin
            st      <= st_nx;
            req_err <= start && !req_enroll && !chal_ok;
            if (start) tgt_row <= dec_row;
        end
    end

    kseq_sweep #(.ROWS(ROWS), .COLS(COLS)) sweep_i (
        .clk(clk), .rst(rst), .load(sw_load), .load_row(load_row),
        .whole(in_enroll), .step(sw_step),
        .row(cell_row), .col(cell_col), .last(last));

    kseq_capture #(.COLS(COLS)) cap_i (
        .clk(clk), .rst(rst), .we(accept && st == ST_IREAD),
        .idx(cell_col), .bit_in(cell_bit), .data(resp_key));

    assign busy           = (st != ST_IDLE);
    assign cell_cmd_valid = st_issues(st);
    assign cell_cmd       = st_to_op(st);
    assign resp_valid     = (st == ST_DONE);

    // R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (cell_cmd_valid && !cell_done) |=> (cell_cmd_valid && $stable(cell_cmd)
            && $stable(cell_row) && $stable(cell_col)));
    // R6
    col_step_chk: assert property (@(posedge clk) disable iff (rst)
        (cell_cmd_valid && cell_done && cell_col != CW'(COLS - 1))
            |=> (cell_col == $past(cell_col) + CW'(1)));
    // R4
    set_tail_chk: assert property (@(posedge clk) disable iff (rst)
        (cell_cmd_valid && cell_cmd == CMD_SET) |=> (!cell_cmd_valid || cell_cmd == CMD_SET));
    // R4
    read_order_chk: assert property (@(posedge clk) disable iff (rst)
        (cell_cmd_valid && cell_cmd == CMD_READ)
            |=> (!cell_cmd_valid || cell_cmd == CMD_READ || cell_cmd == CMD_SET));
    // R7
    resp_busy_chk: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> busy);
    // R7
    resp_release_chk: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> (!busy && !resp_valid));
    // R3
    err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        req_err |-> (!cell_cmd_valid && !busy));
    // R3
    err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        req_err |=> !req_err);
endmodule

// File: tb/kseq_ctrl_tb.sv
module kseq_ctrl_tb_top;
    localparam int NR = 64;
    localparam int NC = 128;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_enroll = 1'b0;
    logic [6:0] req_chal = '0;
    logic busy, req_err, cell_cmd_valid, resp_valid;
    logic [1:0] cell_cmd;
    logic [5:0] cell_row;
    logic [6:0] cell_col;
    logic cell_done = 1'b0, cell_bit = 1'b0;
    logic [NC-1:0] resp_key;

    always #2 clk = ~clk;

    kseq_ctrl dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_enroll(req_enroll),
        .req_chal(req_chal), .busy(busy), .req_err(req_err),
        .cell_cmd_valid(cell_cmd_valid), .cell_cmd(cell_cmd), .cell_row(cell_row),
        .cell_col(cell_col), .cell_done(cell_done), .cell_bit(cell_bit),
        .resp_valid(resp_valid), .resp_key(resp_key));

    int n_checks = 0, n_fail = 0;
    logic [NC-1:0] exp_q[$];
    bit hidden [NR][NC];
    bit formed [NR][NC];
    int k = 0;
    bit mode_en = 0;
    int cur_row = -1;
    bit stream_bad = 0, stab_bad = 0;
    int bad_k = 0;

    task automatic chk(bit ok, string tag, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit fp(int r, int c);
        int h;
        h = r * 37 + c * 101 + r * c;
        h = h ^ (h >> 3);
        return h[1] ^ h[4];
    endfunction

    function automatic logic [NC-1:0] key_of(int r);
        logic [NC-1:0] v;
        for (int c = 0; c < NC; c++) v[c] = fp(r, c);
        return v;
    endfunction

    // expected command for stream position k (R10 encodings)
    task automatic expect_cmd(output int op, output int r, output int c, output bit ok);
        ok = 1;
        if (mode_en) begin
            int i;
            i = k % (NR * NC);
            op = (k < NR * NC) ? 0 : 2;
            r = i / NC; c = i % NC;
            if (k >= 2 * NR * NC) ok = 0;
        end else begin
            int ph;
            ph = k / NC;
            op = (ph == 0) ? 2 : (ph == 1) ? 3 : 1;
            r = cur_row; c = k % NC;
            if (ph > 2 || cur_row < 0) ok = 0;
        end
    endtask

    // array model
    initial begin
        int lat, seed;
        bit have_first;
        logic [1:0] f_cmd;
        logic [5:0] f_row;
        logic [6:0] f_col;
        lat = 0; seed = 7; have_first = 0;
        f_cmd = '0; f_row = '0; f_col = '0;
        for (int r = 0; r < NR; r++)
            for (int c = 0; c < NC; c++) begin
                hidden[r][c] = 1; formed[r][c] = 0;
            end
        forever begin
            @(negedge clk);
            if (cell_done) begin
                cell_done = 0;
                have_first = 0;
                seed = seed * 1103515245 + 12345;
                lat = (seed >>> 16) & 1;
            end else if (cell_cmd_valid) begin
                if (!have_first) begin
                    have_first = 1;
                    f_cmd = cell_cmd; f_row = cell_row; f_col = cell_col;
                end else if (cell_cmd != f_cmd || cell_row != f_row || cell_col != f_col)
                    stab_bad = 1;
                if (lat > 0) lat--;
                else begin
                    int eop, er, ec;
                    bit eok;
                    expect_cmd(eop, er, ec, eok);
                    if (!eok || int'(cell_cmd) != eop || int'(cell_row) != er ||
                        int'(cell_col) != ec) begin
                        if (!stream_bad) bad_k = k;
                        stream_bad = 1;
                    end
                    k++;
                    case (cell_cmd)
                        2'd0: begin formed[cell_row][cell_col] = 1; hidden[cell_row][cell_col] = 1; end
                        2'd1: hidden[cell_row][cell_col] = 1;
                        2'd2: if (formed[cell_row][cell_col]) hidden[cell_row][cell_col] = 0;
                        default: cell_bit = hidden[cell_row][cell_col] ? 1'b1 :
                                            fp(int'(cell_row), int'(cell_col));
                    endcase
                    cell_done = 1;
                end
            end
        end
    end

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && resp_valid) begin
                chk(busy === 1'b1, "R7 busy during resp_valid", busy, 1);
                if (exp_q.size() == 0)
                    chk(0, "R5 unexpected resp_valid", 1, 0);
                else begin
                    logic [NC-1:0] e;
                    e = exp_q.pop_front();
                    chk(resp_key === e, "R5 key mismatch (low 32 bits)", resp_key[31:0], e[31:0]);
                end
                @(negedge clk);
                chk(busy === 1'b0 && resp_valid === 1'b0, "R7 release after resp", busy, 0);
            end
        end
    end

    task automatic do_req(bit en, int chal, bit inject);
        bit good;
        good = en || (chal >= 1 && chal <= NR);
        @(negedge clk);
        k = 0; stream_bad = 0; stab_bad = 0;
        mode_en = en; cur_row = good ? (en ? 0 : chal - 1) : -1;
        if (!en && good) exp_q.push_back(key_of(chal - 1));
        req_valid = 1; req_enroll = en; req_chal = 7'(chal);
        @(negedge clk);
        req_valid = 0;
        if (!good) begin
            chk(req_err === 1'b1, "R3 err pulse", req_err, 1);
            chk(busy === 1'b0, "R3 busy stays low", busy, 0);
            @(negedge clk);
            chk(req_err === 1'b0, "R3 err one cycle", req_err, 0);
            repeat (20) @(negedge clk);
            chk(k == 0, "R3 no command on reject", k, 0);
            return;
        end
        chk(busy === 1'b1, "R7 busy after request", busy, 1);
        chk(req_err === 1'b0, "R3 no err on valid", req_err, 0);
        if (inject) begin
            repeat (30) @(negedge clk);
            req_valid = 1; req_enroll = 1; req_chal = 7'd5;
            @(negedge clk);
            req_valid = 0;
        end
        while (busy) @(negedge clk);
        if (en) chk(k == 2 * NR * NC, "R8 enrollment command count", k, 2 * NR * NC);
        else chk(k == 3 * NC, inject ? "R9 busy request ignored, count" : "R4 command count", k, 3 * NC);
        chk(!stream_bad, "R2/R4/R8/R10 command stream, first bad index", bad_k, -1);
        chk(!stab_bad, "R6 command held until done", stab_bad, 0);
        if (!en) begin
            int nh;
            nh = 0;
            for (int c = 0; c < NC; c++) nh += hidden[chal - 1][c];
            chk(nh == NC, "R4 row hidden after access", nh, NC);
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1
        chk(busy === 1'b0 && cell_cmd_valid === 1'b0, "R1 reset idle", busy, 0);
        chk(resp_valid === 1'b0 && req_err === 1'b0, "R1 reset strobes", resp_valid, 0);
        rst = 0;
        @(negedge clk);
        chk(busy === 1'b0 && cell_cmd_valid === 1'b0, "R1 after reset", busy, 0);
        do_req(0, 0, 0);
        do_req(1, 0, 0);
        do_req(0, 1, 0);
        do_req(0, 64, 0);
        do_req(0, 65, 0);
        do_req(0, 17, 1);
        do_req(0, 127, 0);
        do_req(0, 1, 0);
        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, "R5 all keys delivered", exp_q.size(), 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule